// File: doc/BRIEF.md
# Split-Screen Grayscale Pixel Filter

This block sits in a streaming video path that carries one 16-bit packed-colour pixel per transfer. It uses a valid/ready handshake in the AXI4-Stream style, with a start-of-frame flag and an end-of-line flag. Each pixel word holds three colour fields. Bits [15:11] hold a 5-bit field A. Bits [10:6] hold a 5-bit field B. Bits [5:0] hold a 6-bit field C.

The block widens the three fields to 8 bits and forms a rounded, weighted luminance from them. It then requantises that luminance and writes it back into all three fields of the same 16-bit layout. The result is a pixel that looks gray but keeps the packed format.

A per-line column position decides which word leaves the block. Columns below half of the active width pass through untouched. Every other column carries the gray word. The result is a split-screen display: original colour on the left, grayscale on the right.

The active width is a runtime input. The block samples it once per frame, on the start-of-frame pixel. The datapath has two register stages, and the whole pipeline stalls as one unit when the output side is not ready.

Top module: `gray_split_filter`

## Requirements
- R1: Field expansion. The field values are widened as A8 = A·8, B8 = B·8 and C8 = C·4. The luminance is gray = floor((76·A8 + 29·B8 + 150·C8 + 128) / 256).
- R2: Gray word layout. The block computes t = min(gray + 4, 255) and q = t[7:3]. The gray word puts q in bits [15:11], q in bits [10:6], q in bits [5:1], and 0 in bit 0.
- R3: Split rule. A pixel whose column is below floor(width / 2) leaves the block exactly as it came in. All other pixels leave as the gray word.
- R4: Column counting. The start-of-frame pixel is column 0. The pixel after an end-of-line pixel is column 0. Every other accepted pixel is one column past the one before it. Only accepted transfers advance the count.
- R5: Width sampling. The width input is taken only with an accepted start-of-frame pixel. Changing the width at any other time does not affect the split until the next frame.
- R6: Flag alignment. Each output word carries the start-of-frame and end-of-line flags of the input pixel it came from. Output words appear in input order.
- R7: Latency. While the output side is ready, a pixel accepted at one clock edge is presented at the output after the second edge that follows.
- R8: Backpressure. While the output is valid and not ready, the output word and its flags hold stable. The input is always ready when the output holds no word. No pixel is lost or duplicated.
- R9: Reset. After reset the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_width | input | 12 | Active line width in pixels, taken with the start-of-frame pixel |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high together with s_valid |
| s_data | input | 16 | Input packed pixel |
| s_user | input | 1 | Start-of-frame flag of the input pixel |
| s_last | input | 1 | End-of-line flag of the input pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 16 | Output packed pixel |
| m_user | output | 1 | Start-of-frame flag travelling with the output pixel |
| m_last | output | 1 | End-of-line flag travelling with the output pixel |

## Verification
Each accepted pixel comes out two edges after its acceptance when the output side is ready. Under backpressure, a word is due once downstream has taken every older word. The bench records the cycle of each acceptance with its expected word. In the phase where downstream is always ready, the bench requires the cycle gap to be exactly two. Under random backpressure it compares words strictly in order and checks that a stalled word holds stable until it is taken.

// File: rtl/gsf_pkg.sv
package gsf_pkg;

  localparam int PIX_W    = 16;
  localparam int WT_A     = 76;
  localparam int WT_B     = 29;
  localparam int WT_C     = 150;
  localparam int LUMA_RND = 128;
  localparam int QNT_RND  = 4;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
  } chan8_t;

  // widen the three packed fields to 8 bits each
  function automatic chan8_t widen(input logic [PIX_W-1:0] p);
    chan8_t r;
    r.a = {p[15:11], 3'b000};
    r.b = {p[10:6],  3'b000};
    r.c = {p[5:0],   2'b00};
    return r;
  endfunction

  // weighted sum including rounding constant; the maximum fits 16 bits
  function automatic logic [15:0] weigh(input chan8_t ch);
    logic [15:0] s;
    s = ({8'd0, ch.a} * 16'(WT_A)) + ({8'd0, ch.b} * 16'(WT_B))
      + ({8'd0, ch.c} * 16'(WT_C)) + 16'(LUMA_RND);
    return s;
  endfunction

  function automatic logic [7:0] luma(input logic [15:0] s);
    return s[15:8];
  endfunction

  // requantise with saturation and replicate into the packed layout
  function automatic logic [PIX_W-1:0] repack(input logic [7:0] g);
    logic [8:0] g4;
    logic [7:0] sat;
    logic [4:0] q;
    g4  = {1'b0, g} + 9'(QNT_RND);
    sat = g4[8] ? 8'hFF : g4[7:0];
    q   = sat[7:3];
    return {q, q, q, 1'b0};
  endfunction

endpackage

// File: rtl/gsf_column_tracker.sv
module gsf_column_tracker #(
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sof,
  input  logic             eol,
  input  logic [COL_W-1:0] width,
  output logic             pass,
  output logic [COL_W-1:0] col_q,
  output logic [COL_W-1:0] half_q
);

  logic [COL_W-1:0] pix_col;
  logic [COL_W-1:0] thresh;

  assign pix_col = sof ? '0 : col_q;
  assign thresh  = sof ? (width >> 1) : half_q;
  assign pass    = pix_col < thresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      half_q <= '0;
    end else if (fire) begin
      if (sof) half_q <= width >> 1;
      if (eol)      col_q <= '0;
      else          col_q <= pix_col + COL_W'(1);
    end
  end

endmodule

// File: rtl/gsf_luma_pipe.sv
module gsf_luma_pipe
  import gsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_pass,
  input  logic             in_user,
  input  logic             in_last,
  output logic             st1_valid,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_pass,
  output logic             out_user,
  output logic             out_last
);

  // stage 1: products and sum
  logic [15:0]      s1_sum;
  logic [PIX_W-1:0] s1_data;
  logic             s1_pass, s1_user, s1_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_valid <= 1'b0;
      s1_sum    <= '0;
      s1_data   <= '0;
      s1_pass   <= 1'b0;
      s1_user   <= 1'b0;
      s1_last   <= 1'b0;
    end else if (en) begin
      st1_valid <= in_valid;
      if (in_valid) begin
        s1_sum  <= weigh(widen(in_data));
        s1_data <= in_data;
        s1_pass <= in_pass;
        s1_user <= in_user;
        s1_last <= in_last;
      end
    end
  end

  // stage 2: scale, requantise, select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_pass  <= 1'b0;
      out_user  <= 1'b0;
      out_last  <= 1'b0;
    end else if (en) begin
      out_valid <= st1_valid;
      if (st1_valid) begin
        out_data <= s1_pass ? s1_data : repack(luma(s1_sum));
        out_pass <= s1_pass;
        out_user <= s1_user;
        out_last <= s1_last;
      end
    end
  end

endmodule

// File: rtl/gray_split_filter.sv
module gray_split_filter
  import gsf_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] s_width,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_data,
  input  logic             s_user,
  input  logic             s_last,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_data,
  output logic             m_user,
  output logic             m_last
);

  // named internal events, observed by the bound checker
  logic             adv;
  logic             in_fire;
  logic             col_pass;
  logic [COL_W-1:0] col_dbg;
  logic [COL_W-1:0] half_dbg;
  logic             st1_dbg;
  logic             pass_dbg;

  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;
  assign in_fire = s_valid && adv;

  gsf_column_tracker #(.COL_W(COL_W)) u_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (in_fire),
    .sof    (s_user),
    .eol    (s_last),
    .width  (s_width),
    .pass   (col_pass),
    .col_q  (col_dbg),
    .half_q (half_dbg)
  );

  gsf_luma_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv),
    .in_valid  (s_valid),
    .in_data   (s_data),
    .in_pass   (col_pass),
    .in_user   (s_user),
    .in_last   (s_last),
    .st1_valid (st1_dbg),
    .out_valid (m_valid),
    .out_data  (m_data),
    .out_pass  (pass_dbg),
    .out_user  (m_user),
    .out_last  (m_last)
  );

endmodule

// File: rtl/gsf_checker.sv
module gsf_checker #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_user,
  input logic             s_last,
  input logic             m_valid,
  input logic             m_ready,
  input logic [15:0]      m_data,
  input logic             m_user,
  input logic             m_last,
  input logic [COL_W-1:0] col_q,
  input logic [COL_W-1:0] half_q,
  input logic             st1_valid,
  input logic             out_pass
);

  logic acc;
  assign acc = s_valid && s_ready;

  p_gray_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !out_pass) |-> (m_data[15:11] == m_data[10:6]) &&
                               (m_data[5:1] == m_data[15:11]) && !m_data[0]);

  p_sof_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_user && !s_last) |=> (col_q == COL_W'(1)));

  p_eol_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_last) |=> (col_q == '0));

  p_width_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && s_user) |=> $stable(half_q));

  p_stage_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> st1_valid);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) &&
                              $stable(m_user) && $stable(m_last));

  p_empty_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |=> !m_valid);

endmodule

bind gray_split_filter gsf_checker #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_user    (s_user),
  .s_last    (s_last),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .m_user    (m_user),
  .m_last    (m_last),
  .col_q     (col_dbg),
  .half_q    (half_dbg),
  .st1_valid (st1_dbg),
  .out_pass  (pass_dbg)
);

// File: tb/tb_gray_split_filter.sv
module tb_gray_split_filter;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;

  typedef struct {
    logic [15:0] data;
    logic        user;
    logic        last;
    logic        pass;
    int          cyc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] s_width = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        s_user = 1'b0;
  logic        s_last = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_data;
  logic        m_user;
  logic        m_last;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   lat_mode = 1'b0;
  bit   bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t q[$];

  int bcol = 0;
  int bhalf = 0;

  gray_split_filter dut (
    .clk(clk), .rst_n(rst_n), .s_width(s_width), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_user(s_user), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_user(m_user), .m_last(m_last)
  );

  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  function automatic void check(input bit ok, input string req,
                                input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  // model of the gray word, written from R1 and R2
  function automatic logic [15:0] model_gray(input logic [15:0] p);
    int fa, fb, fc, y, t, k;
    fa = (p / 2048) % 32;
    fb = (p / 64) % 32;
    fc = p % 64;
    y  = ((fa * 8) * 76 + (fb * 8) * 29 + (fc * 4) * 150 + 128) / 256;
    t  = (y + 4 > 255) ? 255 : y + 4;
    k  = t / 8;
    return 16'(k * 2048 + k * 64 + k * 2);
  endfunction

  task automatic send(input logic [15:0] d, input bit u, input bit l);
    exp_t e;
    bit pass;
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_user = u; s_last = l;
    forever begin
      #(HALF - 1);
      if (s_ready) break;
      @(negedge clk);
    end
    // R4/R5 bench model of the column and threshold
    if (u) begin bcol = 0; bhalf = s_width / 2; end
    pass = bcol < bhalf;
    e.data = pass ? d : model_gray(d);
    e.user = u; e.last = l; e.pass = pass; e.cyc = cyc;
    q.push_back(e);
    bcol = l ? 0 : bcol + 1;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0; s_user = 1'b0; s_last = 1'b0;
  endtask

  // monitor: pops in order, checks word, flags, latency and stall hold
  bit          held = 1'b0;
  logic [17:0] held_v;
  initial begin
    forever begin
      @(negedge clk);
      #(HALF - 1);
      if (held && m_valid)
        check({m_data, m_user, m_last} == held_v, "R8 stall hold",
              {14'd0, m_data, m_user, m_last}, {14'd0, held_v});
      held = m_valid && !m_ready;
      held_v = {m_data, m_user, m_last};
      if (m_valid && m_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R8 unexpected output", {16'd0, m_data}, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(m_data == e.data, e.pass ? "R3 passthrough" : "R1 R2 gray word",
                {16'd0, m_data}, {16'd0, e.data});
          check({m_user, m_last} == {e.user, e.last}, "R6 flags",
                {30'd0, m_user, m_last}, {30'd0, e.user, e.last});
          if (lat_mode)
            check(cyc - e.cyc == 2, "R7 latency", cyc - e.cyc, 32'd2);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(m_valid == 1'b0, "R9 reset valid", {31'd0, m_valid}, 32'd0);
    check(s_ready == 1'b1, "R9 reset ready", {31'd0, s_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(m_valid == 1'b0, "R9 idle after reset", {31'd0, m_valid}, 32'd0);

    // phase A: steady ready, width 8, field patterns (R1 R2 R3 R7)
    lat_mode = 1'b1;
    s_width = 12'd8;
    begin
      logic [15:0] pat [8] = '{16'h0000, 16'hFFFF, 16'hF800, 16'h07C0,
                               16'h003F, 16'h1234, 16'hA5A5, 16'h5A5A};
      for (int ln = 0; ln < 2; ln++)
        for (int i = 0; i < 8; i++)
          send(ln == 0 ? pat[i] : pat[7 - i], (ln == 0) && (i == 0), i == 7);
    end
    idle();
    repeat (4) @(posedge clk);

    // phase B: width 6, width changed mid-frame (R5), short line (R4)
    s_width = 12'd6;
    for (int i = 0; i < 6; i++) begin
      send(16'hFFFF, i == 0, i == 5);
      if (i == 1) s_width = 12'd2;
    end
    for (int i = 0; i < 3; i++) send(16'h8421, 1'b0, i == 2);
    for (int i = 0; i < 6; i++) send(16'hF81F, 1'b0, i == 5);
    // new frame mid-line restarts at column 0 with width 2 (R4 R5)
    send(16'h07FF, 1'b0, 1'b0);
    send(16'h07FF, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send(16'hC3C3, i == 0, i == 3);
    idle();
    repeat (4) @(posedge clk);
    lat_mode = 1'b0;

    // phase C: random backpressure and data, width 10 (R8 R6)
    bp_mode = 1'b1;
    s_width = 12'd10;
    for (int i = 0; i < 60; i++)
      send(lfsr ^ 16'(i * 40503), i == 0, (i % 10) == 9);
    idle();
    repeat (40) @(posedge clk);
    bp_mode = 1'b0;
    repeat (10) @(posedge clk);
    check(q.size() == 0, "R8 all delivered", q.size(), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule